// File: doc/BRIEF.md
# SMM-Only Memory Window Lock Controller

This block owns one 8-bit control register in configuration space and uses it to guard a fixed 128 KiB region of low memory that is meant for system management mode (SMM) code. Firmware first writes a probe code to learn whether the feature exists. While the feature is probed but not yet locked, the region stays open to ordinary code, so firmware can install its SMM handler there. Firmware then sets a lock bit. The lock holds until reset.

Once the lock is set, memory accesses made outside SMM that touch the region are filtered. Reads return all ones and writes are dropped. Accesses made in SMM reach memory unchanged. The filter sits between the requester and the memory. It is combinational: it gives a pass/block decision, a gated write strobe and substituted read data for each request. A static parameter can remove the feature. The register then becomes plain storage and the filter never blocks.

Top module: `smm_window_guard`

## Requirements
- R1: After reset, the control byte reads 0x00. It sits at configuration byte offset 0x9C, which is dword index 0x27, byte lane 0, bits [7:0] of `cfg_rdata`. A read of any other dword returns zero.
- R2: In the reset state, a write of 0xFF is a probe. The byte then reads 0x01 and only bit 1 stays writable.
- R3: In the reset state, a write of any value other than 0xFF is discarded and the byte keeps reading 0x00.
- R4: After the probe, a write with bit 1 set locks the block and the byte reads 0x02. A write with bit 1 clear leaves it at 0x01.
- R5: Once locked, every further write is ignored and the byte reads 0x02 until reset. Reset returns the byte to 0x00 and removes the lock.
- R6: A configuration write that addresses another dword, or whose byte enable bit 0 is clear, leaves the byte and the lock unchanged.
- R7: The window spans byte addresses 0x30000 to 0x4FFFF inclusive. While the block is unlocked, every access passes and read data comes from memory.
- R8: While locked, a non-SMM read of 1 to 4 bytes that touches the window is blocked (`mem_pass`=0, `mem_block`=1), and `mem_rdata` is 0xFFFFFFFF.
- R9: While locked, a non-SMM write that touches the window is dropped (`mem_we_out`=0).
- R10: While locked, SMM accesses to the window pass. Read data comes from memory, and writes are forwarded with their data.
- R11: An access that only partly overlaps the window is blocked under the R8/R9 conditions. An access lying wholly outside the window always passes.
- R12: With `ENABLE`=0, the byte is plain read/write storage: any written value reads back unchanged. The filter never blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_dw` |
| mem_req | input | 1 | Memory access request valid |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_smm | input | 1 | Requester is in SMM |
| mem_addr | input | ADDR_W | Byte address of the access |
| mem_len | input | 3 | Access length in bytes, 1 to 4 |
| mem_wdata | input | 32 | Write data from the requester |
| mem_rdata_in | input | 32 | Read data returned by memory |
| mem_pass | output | 1 | Access is forwarded to memory |
| mem_block | output | 1 | Access is filtered |
| mem_we_out | output | 1 | Write strobe forwarded to memory |
| mem_wdata_out | output | 32 | Write data forwarded to memory |
| mem_rdata | output | 32 | Read data returned to the requester |

## Verification
The probe/lock sequence is driven with several kinds of writes:
- the probe code and a non-probe value, which separate a probe from a discarded write;
- values after the probe with bit 1 clear (0x00, 0xFD) and with bit 1 set, which show that only the masked bit matters;
- writes to the wrong byte lane or dword, which show the decode leaves the state alone.

The filter is then tried with addresses placed around the window boundaries: the first and last window bytes, the bytes just outside, and 4-byte accesses that straddle each edge. Each of these is combined with SMM and non-SMM requests, reads and writes, and the locked and unlocked states. A second instance built with the feature off receives the same writes and shows plain storage with no blocking.

// File: rtl/smm_guard_pkg.sv
// Package: shared codes and state type for the SMM window guard.
// Assumes one control byte per instance.
package smm_guard_pkg;

    // Probe code that firmware writes to discover the feature.
    localparam logic [7:0] PROBE_CODE   = 8'hFF;
    // Value read back once the probe has been accepted.
    localparam logic [7:0] FEATURE_CODE = 8'h01;
    // Value read back once the window is locked.
    localparam logic [7:0] LOCKED_CODE  = 8'h02;
    // Bit position of the lock request inside the control byte.
    localparam int         LOCK_BIT     = 1;

    // Life cycle of the control byte.
    typedef enum logic [1:0] {
        GUARD_OPEN   = 2'd0,
        GUARD_ARMED  = 2'd1,
        GUARD_LOCKED = 2'd2
    } guard_state_e;

endpackage

// File: rtl/smm_guard_ctrl.sv
// Module: control byte of the guard. It runs the probe/lock handshake
// under a write mask that depends on the current state.
// Assumes wr_hit is already qualified by address and byte enable.
// With ENABLE=0 the byte is plain storage and never locks.
module smm_guard_ctrl
    import smm_guard_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wbyte,
    output logic [7:0] reg_val,
    output logic       locked
);

    generate
        if (ENABLE) begin : g_guard
            guard_state_e state_q;
            guard_state_e state_d;
            logic [7:0]   wmask;
            logic [7:0]   cur_val;
            logic [7:0]   merged;

            // Write mask and read value for each state.
            always_comb begin
                case (state_q)
                    GUARD_OPEN: begin
                        wmask   = 8'hFF;
                        cur_val = 8'h00;
                    end
                    GUARD_ARMED: begin
                        wmask   = 8'h01 << LOCK_BIT;
                        cur_val = FEATURE_CODE;
                    end
                    default: begin
                        wmask   = 8'h00;
                        cur_val = LOCKED_CODE;
                    end
                endcase
            end

            // Merge the written byte through the mask.
            assign merged = (cur_val & ~wmask) | (wbyte & wmask);

            // Next state from the merged value.
            always_comb begin
                state_d = state_q;
                if (wr_hit) begin
                    case (state_q)
                        GUARD_OPEN:
                            if (merged == PROBE_CODE) state_d = GUARD_ARMED;
                        GUARD_ARMED:
                            if (merged[LOCK_BIT]) state_d = GUARD_LOCKED;
                        default: state_d = state_q;
                    endcase
                end
            end

            // State register with synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) state_q <= GUARD_OPEN;
                else        state_q <= state_d;
            end

            assign reg_val = cur_val;
            assign locked  = (state_q == GUARD_LOCKED);
        end else begin : g_plain
            logic [7:0] store_q;

            // Plain byte storage when the feature is removed.
            always_ff @(posedge clk) begin
                if (!rst_n)      store_q <= 8'h00;
                else if (wr_hit) store_q <= wbyte;
            end

            assign reg_val = store_q;
            assign locked  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/smm_guard_decode.sv
// Module: decides whether a 1..4 byte access touches the window.
// Assumes mem_len is 1..4; a length of 0 is treated as 1 byte.
// The arithmetic is one bit wider than the address so the end never wraps.
module smm_guard_decode #(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0003_0000,
    parameter int unsigned     WIN_SIZE = 32'h0002_0000
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [2:0]        mem_len,
    output logic              in_win
);

    localparam int AW1 = ADDR_W + 1;
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + AW1'(WIN_SIZE) - AW1'(1);

    logic [ADDR_W:0] first_b;
    logic [ADDR_W:0] last_b;
    logic [2:0]      span;

    // First and last byte of the access.
    always_comb begin
        span    = (mem_len == 3'd0) ? 3'd0 : mem_len - 3'd1;
        first_b = {1'b0, mem_addr};
        last_b  = first_b + AW1'(span);
    end

    // Any byte of the access inside the window counts.
    assign in_win = (last_b >= WIN_LO) && (first_b <= WIN_HI);

endmodule

// File: rtl/smm_guard_filter.sv
// Module: gates one memory access. It blocks a non-SMM access to the
// window while locked, substitutes all-ones read data and drops writes.
// Assumes the decision is combinational within the request cycle.
module smm_guard_filter #(
    parameter int DATA_W = 32
) (
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic              mem_smm,
    input  logic              locked,
    input  logic              in_win,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata_in,
    output logic              mem_pass,
    output logic              mem_block,
    output logic              mem_we_out,
    output logic [DATA_W-1:0] mem_wdata_out,
    output logic [DATA_W-1:0] mem_rdata
);

    // Pass/block decision and substituted read data.
    always_comb begin
        mem_block     = mem_req && in_win && locked && !mem_smm;
        mem_pass      = mem_req && !mem_block;
        mem_we_out    = mem_pass && mem_we;
        mem_wdata_out = mem_wdata;
        mem_rdata     = mem_block ? {DATA_W{1'b1}} : mem_rdata_in;
    end

endmodule

// File: rtl/smm_window_guard.sv
// Module: top of the SMM window guard. It decodes the configuration
// dword port down to the control byte, and it connects the control byte,
// the window decode and the access filter.
// Assumes the control byte offset is fixed by CFG_OFFSET.
module smm_window_guard #(
    parameter bit              ENABLE     = 1'b1,
    parameter int              ADDR_W     = 32,
    parameter logic [7:0]      CFG_OFFSET = 8'h9C,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0003_0000,
    parameter int unsigned     WIN_SIZE   = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [5:0]        cfg_dw,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic              mem_smm,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [2:0]        mem_len,
    input  logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata_in,
    output logic              mem_pass,
    output logic              mem_block,
    output logic              mem_we_out,
    output logic [31:0]       mem_wdata_out,
    output logic [31:0]       mem_rdata
);

    localparam logic [5:0] OFF_DW   = CFG_OFFSET[7:2];
    localparam int         OFF_LANE = int'(CFG_OFFSET[1:0]);

    logic       wr_hit;
    logic [7:0] wbyte;
    logic [7:0] reg_val;
    logic       locked;
    logic       in_win;
    logic       unused_lanes;

    // Write qualification: right dword and the byte lane enabled.
    assign wr_hit = cfg_wr && (cfg_dw == OFF_DW) && cfg_be[OFF_LANE];
    assign wbyte  = cfg_wdata[OFF_LANE*8 +: 8];
    assign unused_lanes = ^cfg_wdata;

    // Read mux: control byte in its lane, zero elsewhere.
    assign cfg_rdata = (cfg_dw == OFF_DW) ? (32'(reg_val) << (OFF_LANE * 8)) : 32'h0;

    smm_guard_ctrl #(
        .ENABLE (ENABLE)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wbyte   (wbyte),
        .reg_val (reg_val),
        .locked  (locked)
    );

    smm_guard_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_decode (
        .mem_addr (mem_addr),
        .mem_len  (mem_len),
        .in_win   (in_win)
    );

    smm_guard_filter #(
        .DATA_W (32)
    ) u_filter (
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_smm       (mem_smm),
        .locked        (locked),
        .in_win        (in_win),
        .mem_wdata     (mem_wdata),
        .mem_rdata_in  (mem_rdata_in),
        .mem_pass      (mem_pass),
        .mem_block     (mem_block),
        .mem_we_out    (mem_we_out),
        .mem_wdata_out (mem_wdata_out),
        .mem_rdata     (mem_rdata)
    );

endmodule

// File: rtl/smm_window_guard_chk.sv
// Checker: temporal properties of the SMM window guard. It is bound to
// every instance of the top and reads its internal lock and byte state.
module smm_window_guard_chk #(
    parameter bit ENABLE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic       wr_hit,
    input logic [7:0] reg_val,
    input logic       locked,
    input logic       mem_req,
    input logic       mem_we,
    input logic       mem_smm,
    input logic       mem_pass,
    input logic       mem_block,
    input logic       mem_we_out,
    input logic [31:0] mem_rdata
);

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reg_val == 8'h00 && !locked));

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R6
    miss_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !wr_hit) |=> $stable(reg_val));

    // R7
    open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !locked) |-> mem_pass);

    // R8
    block_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_block && !mem_we) |-> (mem_rdata == 32'hFFFF_FFFF));

    // R9
    block_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_block |-> !mem_we_out);

    // R10
    smm_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_smm) |-> (mem_pass && (mem_we_out == mem_we)));

    generate
        if (!ENABLE) begin : g_off
            // R12
            off_never_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mem_req |-> (mem_pass && !mem_block));
        end
    endgenerate

endmodule

bind smm_window_guard smm_window_guard_chk #(
    .ENABLE (ENABLE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .wr_hit     (wr_hit),
    .reg_val    (reg_val),
    .locked     (locked),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_smm    (mem_smm),
    .mem_pass   (mem_pass),
    .mem_block  (mem_block),
    .mem_we_out (mem_we_out),
    .mem_rdata  (mem_rdata)
);

// File: tb/smm_window_guard_test.sv
// Directed bench for the SMM window guard. One task per scenario.
// Inputs change on the falling edge; outputs are sampled 1 ns later.
module smm_window_guard_test;

    localparam logic [5:0]  CTRL_DW = 6'h27;
    localparam logic [31:0] MEMVAL  = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = CTRL_DW;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata, cfg_rdata_off;
    logic        mem_req = 1'b0;
    logic        mem_we = 1'b0;
    logic        mem_smm = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic [2:0]  mem_len = 3'd1;
    logic [31:0] mem_wdata = 32'hA5A5_0F0F;
    logic [31:0] mem_rdata_in = MEMVAL;
    logic        mem_pass, mem_block, mem_we_out;
    logic [31:0] mem_wdata_out, mem_rdata;
    logic        off_pass, off_block, off_we;
    logic [31:0] off_wdata, off_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    smm_window_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_smm(mem_smm),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
        .mem_rdata_in(mem_rdata_in), .mem_pass(mem_pass),
        .mem_block(mem_block), .mem_we_out(mem_we_out),
        .mem_wdata_out(mem_wdata_out), .mem_rdata(mem_rdata)
    );

    smm_window_guard #(.ENABLE(1'b0)) uut_off (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_off),
        .mem_req(mem_req), .mem_we(mem_we), .mem_smm(mem_smm),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
        .mem_rdata_in(mem_rdata_in), .mem_pass(off_pass),
        .mem_block(off_block), .mem_we_out(off_we),
        .mem_wdata_out(off_wdata), .mem_rdata(off_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [7:0] b);
        @(negedge clk);
        cfg_dw = dw; cfg_be = be; cfg_wdata = {4{b}}; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_dw = CTRL_DW; cfg_be = 4'h0;
        #1;
    endtask

    task automatic read_ctrl(input string req, input logic [7:0] exp);
        cfg_dw = CTRL_DW;
        #1;
        check(req, cfg_rdata, {24'h0, exp});
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic [2:0] len,
                          input logic we, input logic smm, input logic exp_block);
        @(negedge clk);
        mem_req = 1'b1; mem_addr = a; mem_len = len; mem_we = we; mem_smm = smm;
        #1;
        check(req, {31'h0, mem_block}, {31'h0, exp_block});
        check(req, {31'h0, mem_pass}, {31'h0, !exp_block});
        if (we) begin
            check(req, {31'h0, mem_we_out}, {31'h0, !exp_block});
            check(req, mem_wdata_out, mem_wdata);
        end else begin
            check(req, mem_rdata, exp_block ? 32'hFFFF_FFFF : MEMVAL);
        end
        @(negedge clk);
        mem_req = 1'b0; mem_we = 1'b0; mem_smm = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        read_ctrl("R1 reset byte", 8'h00);
        cfg_dw = 6'h26; #1;
        check("R1 other dword reads zero", cfg_rdata, 32'h0);
        cfg_dw = CTRL_DW;
    endtask

    task automatic t_discard_and_miss();
        cfg_write(CTRL_DW, 4'h1, 8'h5A);
        read_ctrl("R3 non-probe discarded", 8'h00);
        cfg_write(CTRL_DW, 4'h2, 8'hFF);
        read_ctrl("R6 lane disabled", 8'h00);
        cfg_write(6'h26, 4'hF, 8'hFF);
        read_ctrl("R6 wrong dword", 8'h00);
    endtask

    task automatic t_open_window();
        access("R7 open read base", 32'h0003_0000, 3'd4, 1'b0, 1'b0, 1'b0);
        access("R7 open write", 32'h0004_0000, 3'd2, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_probe_lock();
        cfg_write(CTRL_DW, 4'h1, 8'hFF);
        read_ctrl("R2 probe reads 01", 8'h01);
        access("R7 armed still open", 32'h0004_FFFF, 3'd1, 1'b0, 1'b0, 1'b0);
        cfg_write(CTRL_DW, 4'h1, 8'h00);
        read_ctrl("R4 bit1 clear keeps 01", 8'h01);
        cfg_write(CTRL_DW, 4'h1, 8'hFD);
        read_ctrl("R4 FD keeps 01", 8'h01);
        cfg_write(CTRL_DW, 4'hE, 8'h02);
        read_ctrl("R6 lane miss while armed", 8'h01);
        cfg_write(CTRL_DW, 4'h1, 8'h02);
        read_ctrl("R4 lock reads 02", 8'h02);
    endtask

    task automatic t_locked_writes();
        cfg_write(CTRL_DW, 4'h1, 8'hFF);
        read_ctrl("R5 locked ignores FF", 8'h02);
        cfg_write(CTRL_DW, 4'h1, 8'h00);
        read_ctrl("R5 locked ignores 00", 8'h02);
    endtask

    task automatic t_locked_filter();
        access("R8 first byte", 32'h0003_0000, 3'd1, 1'b0, 1'b0, 1'b1);
        access("R8 last byte", 32'h0004_FFFF, 3'd1, 1'b0, 1'b0, 1'b1);
        access("R8 mid dword", 32'h0004_0000, 3'd4, 1'b0, 1'b0, 1'b1);
        access("R11 below window", 32'h0002_FFFF, 3'd1, 1'b0, 1'b0, 1'b0);
        access("R11 above window", 32'h0005_0000, 3'd4, 1'b0, 1'b0, 1'b0);
        access("R11 straddle low", 32'h0002_FFFE, 3'd4, 1'b0, 1'b0, 1'b1);
        access("R11 straddle high", 32'h0004_FFFE, 3'd4, 1'b1, 1'b0, 1'b1);
        access("R11 ends just below", 32'h0002_FFFC, 3'd4, 1'b0, 1'b0, 1'b0);
        access("R9 write dropped", 32'h0004_0000, 3'd4, 1'b1, 1'b0, 1'b1);
        access("R10 smm read", 32'h0004_0000, 3'd4, 1'b0, 1'b1, 1'b0);
        access("R10 smm write", 32'h0003_0000, 3'd1, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_reset_unlocks();
        do_reset();
        read_ctrl("R5 reset clears lock", 8'h00);
        access("R5 open after reset", 32'h0004_0000, 3'd4, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_disabled();
        cfg_write(CTRL_DW, 4'h1, 8'h5A);
        cfg_dw = CTRL_DW; #1;
        check("R12 plain store 5A", cfg_rdata_off, 32'h0000_005A);
        cfg_write(CTRL_DW, 4'h1, 8'hFF);
        cfg_write(CTRL_DW, 4'h1, 8'h02);
        cfg_dw = CTRL_DW; #1;
        check("R12 plain store 02", cfg_rdata_off, 32'h0000_0002);
        @(negedge clk);
        mem_req = 1'b1; mem_addr = 32'h0004_0000; mem_len = 3'd4; mem_we = 1'b0; mem_smm = 1'b0;
        #1;
        check("R12 never blocks", {31'h0, off_block}, 32'h0);
        check("R12 data from memory", off_rdata, MEMVAL);
        check("R8 enabled copy blocks", mem_rdata, 32'hFFFF_FFFF);
        @(negedge clk);
        mem_req = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_discard_and_miss();
        t_open_window();
        t_probe_lock();
        t_locked_writes();
        t_locked_filter();
        t_reset_unlocks();
        t_disabled();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule